// File: doc/BRIEF.md
# PLL Retune Sequencer

This block steps a phase-locked loop from one set of coefficients (reference divider M, feedback multiplier N, post-divider code PL) to another without disturbing the clock it feeds. It owns the PLL control state: the coefficient fields, the enable, power-down and lock-detect-disable bits, the output source select and the output divider fields. A request strobe carries the target coefficients, and a lock input reports PLL lock. The block pulses `done` when the operation ends. `err` reports a failed retune.

The sequencer picks the gentlest path that reaches the target. If only N changes on a running PLL, it asks the external N-ramp unit to glide N and does nothing else. Otherwise it first glides N down to the lowest legal value and halves the output through a temporary divide-by-2. It then moves the output onto the bypass clock and reprograms the PLL while the PLL is off. Once lock returns, it moves the output back and restores the divider. Last, it glides N up to the target. If the gliding attempt fails, the whole retune is repeated once as a hard jump with no glide.

The block also has a shutdown sequence and an initialization write of the output control fields.

Top module: `pll_retune_seq`

## Requirements
- R1: After reset, `pll_pd`=1, `lockdet_off`=1, `pll_en`=0, `vco_sel`=0, `vco_div`=0, `byp_div`=0, `out_mode`=0, `coef_m`=1, `coef_n`=64, `coef_pl`=0, and `busy`, `err` and `done` are 0.
- R2: A program request is handled by a ramp only when all of these hold: `pll_en`=1, target M equals `coef_m`, and target PL equals `coef_pl`. The ramp goes to the target N. `vco_sel` stays 1 and `vco_div` is not written.
- R3: N_lo(M) = ceil(M × MIN_VCO_KHZ / REF_KHZ), saturated at 255. A gliding retune of an enabled PLL first ramps N to N_lo of the old M.
- R4: Before the PLL is reprogrammed, `vco_div` is written to 2 and then `vco_sel` is cleared. After that, `pll_pd` is cleared and then `pll_en` is cleared. `coef_m` and `coef_pl` change only while `pll_en`=0.
- R5: The coefficient write loads the new M and PL. It loads N = N_lo(new M) when gliding and the target N when not.
- R6: After `pll_en` is set and `lockdet_off` is cleared, the block waits for `pll_lock` for up to LOCK_US × CYC_PER_US cycles. A timeout is a failure.
- R7: After lock, `vco_sel` is set. If `vco_div` is not 0, it is written to 0 with two `div_wr` pulses on consecutive cycles. When gliding, N is then ramped to the target. `vco_sel`=1 only while `pll_en`=1.
- R8: A ramp that gets no `ramp_done` within RAMP_CYC cycles fails. Any failure of a gliding attempt restarts the whole retune once with gliding disabled. A failure of that second attempt sets `err`.
- R9: A shutdown request ramps N to N_lo of the current M if `pll_en`=1. It then clears `vco_sel` and then clears `pll_en`.
- R10: An init request sets `out_mode`=1, `vco_div`=0 and `byp_div`=0x3C with a single `div_wr` pulse.
- R11: Every request ends with a one-cycle `done` pulse, and `err` rises only just before that pulse. `err` stays set until the next request is accepted.
- R12: A ramp to an N equal to `coef_n` is skipped: no `ramp_go` is issued and the sequence continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_req | input | 1 | Start a retune to tgt_m/tgt_n/tgt_pl |
| tgt_m | input | 8 | Target reference divider |
| tgt_n | input | 8 | Target feedback multiplier |
| tgt_pl | input | 6 | Target post-divider code |
| shut_req | input | 1 | Start the shutdown sequence |
| init_req | input | 1 | Write the initial output control fields |
| pll_lock | input | 1 | PLL lock status |
| ramp_done | input | 1 | N-ramp unit finished its glide |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Sticky failure flag |
| ramp_go | output | 1 | Pulse to start a glide toward coef_n |
| coef_m | output | 8 | Programmed M |
| coef_n | output | 8 | Programmed N |
| coef_pl | output | 6 | Programmed post-divider code |
| pll_en | output | 1 | PLL enable |
| pll_pd | output | 1 | PLL power-down |
| lockdet_off | output | 1 | Lock detector disable |
| vco_sel | output | 1 | 1 selects the VCO output, 0 selects bypass |
| vco_div | output | 6 | VCO output divider field (0 = divide by 1) |
| byp_div | output | 6 | Bypass divider field |
| out_mode | output | 1 | Output control mode bit |
| div_wr | output | 1 | Pulse on each write of the output divider fields |

## Verification
The bench sets REF_KHZ=38400, which gives N_lo values of 27, 53 and 79 for M of 1, 2 and 3. It sets CYC_PER_US=1 and LOCK_US=20, so a lock timeout takes 20 cycles. It sets RAMP_CYC=16, so a hung ramp fails after 16 cycles. These values let a missing lock and a hung ramp occur in both the gliding and the hard-jump attempts within a short run. The default timeouts are far longer, and the run could not reach those cases at them.

// File: rtl/pll_retune_seq.sv
module pll_retune_seq #(
  parameter int REF_KHZ     = 38400,
  parameter int MIN_VCO_KHZ = 1000000,
  parameter int CYC_PER_US  = 100,
  parameter int LOCK_US     = 300,
  parameter int RAMP_CYC    = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       prog_req,
  input  logic [7:0] tgt_m,
  input  logic [7:0] tgt_n,
  input  logic [5:0] tgt_pl,
  input  logic       shut_req,
  input  logic       init_req,
  input  logic       pll_lock,
  input  logic       ramp_done,
  output logic       busy,
  output logic       done,
  output logic       err,
  output logic       ramp_go,
  output logic [7:0] coef_m,
  output logic [7:0] coef_n,
  output logic [5:0] coef_pl,
  output logic       pll_en,
  output logic       pll_pd,
  output logic       lockdet_off,
  output logic       vco_sel,
  output logic [5:0] vco_div,
  output logic [5:0] byp_div,
  output logic       out_mode,
  output logic       div_wr
);
  localparam int LOCK_CYC = LOCK_US * CYC_PER_US;
  localparam int MAXC     = (LOCK_CYC > RAMP_CYC) ? LOCK_CYC : RAMP_CYC;
  localparam int CW       = $clog2(MAXC + 1);

  typedef enum logic [4:0] {
    S_IDLE, S_START, S_RSTART, S_RAMP, S_HALVE, S_BYP, S_PWR, S_DIS, S_COEF,
    S_EN, S_LDET, S_WLOCK, S_VSEL, S_RST1, S_RST2, S_SBYP, S_SDIS, S_FIN
  } st_t;

  st_t st, ret;
  logic [7:0] m_t, n_t, rtgt;
  logic [5:0] pl_t;
  logic       glide, shut;
  logic [CW-1:0] cnt;

  function automatic logic [7:0] nlo(input logic [7:0] mm);
    logic [39:0] t;
    t = (40'(mm) * 40'(MIN_VCO_KHZ) + 40'(REF_KHZ - 1)) / 40'(REF_KHZ);
    return (t > 40'd255) ? 8'd255 : t[7:0];
  endfunction

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ret <= S_IDLE;
      m_t <= '0; n_t <= '0; pl_t <= '0; rtgt <= '0;
      glide <= 1'b0; shut <= 1'b0; cnt <= '0;
      done <= 1'b0; err <= 1'b0; ramp_go <= 1'b0; div_wr <= 1'b0;
      coef_m <= 8'd1; coef_n <= 8'd64; coef_pl <= '0;
      pll_en <= 1'b0; pll_pd <= 1'b1; lockdet_off <= 1'b1;
      vco_sel <= 1'b0; vco_div <= '0; byp_div <= '0; out_mode <= 1'b0;
    end else begin
      done <= 1'b0; ramp_go <= 1'b0; div_wr <= 1'b0;
      case (st)
        S_IDLE: begin
          if (init_req) begin
            err <= 1'b0;
            out_mode <= 1'b1; vco_div <= '0; byp_div <= 6'h3C; div_wr <= 1'b1;
            st <= S_FIN;
          end else if (shut_req) begin
            err <= 1'b0; shut <= 1'b1;
            if (pll_en) begin
              rtgt <= nlo(coef_m); ret <= S_SBYP; st <= S_RSTART;
            end else st <= S_SBYP;
          end else if (prog_req) begin
            err <= 1'b0; shut <= 1'b0; glide <= 1'b1;
            m_t <= tgt_m; n_t <= tgt_n; pl_t <= tgt_pl;
            st <= S_START;
          end
        end
        S_START: begin
          if (glide && pll_en && m_t == coef_m && pl_t == coef_pl) begin
            rtgt <= n_t; ret <= S_FIN; st <= S_RSTART;
          end else if (glide && pll_en) begin
            rtgt <= nlo(coef_m); ret <= S_HALVE; st <= S_RSTART;
          end else st <= S_HALVE;
        end
        S_RSTART: begin
          if (rtgt == coef_n) st <= ret;
          else begin
            coef_n <= rtgt; ramp_go <= 1'b1; cnt <= '0; st <= S_RAMP;
          end
        end
        S_RAMP: begin
          if (ramp_done) st <= ret;
          else if (cnt == CW'(RAMP_CYC - 1)) begin
            if (shut) st <= ret;
            else if (glide) begin glide <= 1'b0; st <= S_START; end
            else begin err <= 1'b1; st <= S_FIN; end
          end else cnt <= cnt + 1'b1;
        end
        S_HALVE: begin vco_div <= 6'd2; div_wr <= 1'b1; st <= S_BYP; end
        S_BYP:   begin vco_sel <= 1'b0; st <= S_PWR; end
        S_PWR:   begin pll_pd <= 1'b0; st <= S_DIS; end
        S_DIS:   begin pll_en <= 1'b0; st <= S_COEF; end
        S_COEF: begin
          coef_m <= m_t; coef_pl <= pl_t;
          coef_n <= glide ? nlo(m_t) : n_t;
          st <= S_EN;
        end
        S_EN:   begin pll_en <= 1'b1; st <= S_LDET; end
        S_LDET: begin lockdet_off <= 1'b0; cnt <= '0; st <= S_WLOCK; end
        S_WLOCK: begin
          if (pll_lock) st <= S_VSEL;
          else if (cnt == CW'(LOCK_CYC - 1)) begin
            if (glide) begin glide <= 1'b0; st <= S_START; end
            else begin err <= 1'b1; st <= S_FIN; end
          end else cnt <= cnt + 1'b1;
        end
        S_VSEL: begin
          vco_sel <= 1'b1;
          if (vco_div != '0) st <= S_RST1;
          else if (glide) begin rtgt <= n_t; ret <= S_FIN; st <= S_RSTART; end
          else st <= S_FIN;
        end
        S_RST1: begin vco_div <= '0; div_wr <= 1'b1; st <= S_RST2; end
        S_RST2: begin
          vco_div <= '0; div_wr <= 1'b1;
          if (glide) begin rtgt <= n_t; ret <= S_FIN; st <= S_RSTART; end
          else st <= S_FIN;
        end
        S_SBYP: begin vco_sel <= 1'b0; st <= S_SDIS; end
        S_SDIS: begin pll_en <= 1'b0; st <= S_FIN; end
        S_FIN:  begin done <= 1'b1; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_vco_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vco_sel |-> pll_en);
  assert_coef_while_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(coef_m) || !$stable(coef_pl)) |-> !pll_en);
  assert_ramp_moves_n_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_go |-> !$stable(coef_n));
  assert_err_then_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |=> done);
  assert_bypass_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_en) |-> !vco_sel);
  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/pll_retune_seq_tb_top.sv
module pll_retune_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic prog_req = 0, shut_req = 0, init_req = 0;
  logic [7:0] tgt_m = 0, tgt_n = 0;
  logic [5:0] tgt_pl = 0;
  logic pll_lock, ramp_done;
  logic busy, done, err, ramp_go, pll_en, pll_pd, lockdet_off, vco_sel, out_mode, div_wr;
  logic [7:0] coef_m, coef_n;
  logic [5:0] coef_pl, vco_div, byp_div;

  always #5 clk = ~clk;

  pll_retune_seq #(.REF_KHZ(38400), .MIN_VCO_KHZ(1000000), .CYC_PER_US(1),
                   .LOCK_US(20), .RAMP_CYC(16)) dut_i (.*);

  int checks = 0, errors = 0;
  logic nolock = 0, ramp_hang = 0;
  int en_cnt = 0, rcnt = 0, rg_cnt = 0, dw_cnt = 0;

  always @(posedge clk) begin
    en_cnt <= pll_en ? en_cnt + 1 : 0;
    if (ramp_go) rcnt <= 2; else if (rcnt > 0) rcnt <= rcnt - 1;
  end
  assign pll_lock  = (en_cnt >= 3) && !nolock;
  assign ramp_done = (rcnt == 1) && !ramp_hang;

  typedef logic [47:0] item_t;
  item_t exp_q[$];
  string tag_q[$];

  function automatic item_t mk(logic e, logic [7:0] m, logic [7:0] n, logic [5:0] pl,
      logic en, logic vs, logic [5:0] vd, logic [3:0] rg, logic [3:0] dw);
    return {11'd0, e, m, n, pl, en, vs, vd, rg, dw};
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R11 actual=unexpected done expected=no done");
        end else begin
          check(tag_q.pop_front(),
                64'(mk(err, coef_m, coef_n, coef_pl, pll_en, vco_sel, vco_div,
                       4'(rg_cnt + int'(ramp_go)), 4'(dw_cnt + int'(div_wr)))),
                64'(exp_q.pop_front()));
        end
        rg_cnt = 0; dw_cnt = 0;
      end else begin
        if (ramp_go) rg_cnt++;
        if (div_wr) dw_cnt++;
      end
    end
  end

  task automatic finish_req(string tag, item_t e);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    prog_req = 0; shut_req = 0; init_req = 0;
    do @(negedge clk); while (busy);
    @(negedge clk);
  endtask

  task automatic prog(string tag, logic [7:0] m, logic [7:0] n, logic [5:0] pl, item_t e);
    @(negedge clk); tgt_m = m; tgt_n = n; tgt_pl = pl; prog_req = 1;
    finish_req(tag, e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset", 64'({pll_pd, lockdet_off, pll_en, vco_sel, busy, err, done, out_mode,
                           coef_m, coef_n, coef_pl, vco_div, byp_div}),
          64'({8'b11000000, 8'd1, 8'd64, 6'd0, 6'd0, 6'd0}));

    @(negedge clk); init_req = 1;
    finish_req("R10 init", mk(0, 1, 64, 0, 0, 0, 0, 0, 1));
    check("R10 init fields", 64'({out_mode, byp_div}), 64'({1'b1, 6'h3C}));

    prog("R5 R7 cold retune", 1, 40, 2, mk(0, 1, 40, 2, 1, 1, 0, 1, 3));
    check("R6 lock path bits", 64'({pll_pd, lockdet_off}), 64'(0));
    prog("R2 ramp only", 1, 60, 2, mk(0, 1, 60, 2, 1, 1, 0, 1, 0));
    prog("R12 same N", 1, 60, 2, mk(0, 1, 60, 2, 1, 1, 0, 0, 0));
    prog("R3 R4 glide retune", 2, 100, 3, mk(0, 2, 100, 3, 1, 1, 0, 2, 3));

    nolock = 1;
    prog("R6 R8 lock fail both", 3, 90, 3, mk(1, 3, 90, 3, 1, 0, 2, 1, 2));
    check("R11 err sticky", 64'(err), 64'(1));
    nolock = 0; ramp_hang = 1;
    prog("R8 ramp hang retry", 3, 95, 3, mk(0, 3, 95, 3, 1, 1, 0, 1, 3));
    ramp_hang = 0;

    @(negedge clk); shut_req = 1;
    finish_req("R9 shutdown", mk(0, 3, 79, 3, 0, 0, 0, 1, 0));
    @(negedge clk); shut_req = 1;
    finish_req("R9 shutdown idle", mk(0, 3, 79, 3, 0, 0, 0, 0, 0));

    check("R11 queue drained", 64'(exp_q.size()), 64'(0));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule